// File: doc/BRIEF.md
# I2C Channel Configuration Register Target

This block is an I2C target that stores one 8-bit configuration byte for each of three channels and presents all of them as a parallel word to the analog control logic beside it. The bus lines are sampled with the system clock. START and STOP are found from their edges, and the target answers to a 7-bit address. The upper five bits of that address are fixed and the lower two come from strap pins, so up to four copies can share one bus.

A write is one transaction. The master sends the address with the write bit, then a sub-address byte that picks the channel, then exactly one data byte, then STOP. A read takes two transactions. The first is a write that carries only the sub-address and ends with STOP, which leaves a read pointer behind. The second is a read transaction, in which the target returns the byte the pointer selects and the master answers with NACK and STOP. Every transaction moves exactly one register, and the sub-address never advances on its own.

SDA is driven open-drain. The output `sdaLow` pulls the line low when it is 1 and releases it when it is 0. The target never stretches the clock.

Top module: `chanRegI2c`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits, sent MSB first, equal binary 01011 followed by `strap[1]` and `strap[0]`. The eighth bit is 0 for a write and 1 for a read. An acknowledge is SDA held low through the high phase of the ninth SCL clock.
- R2: When the address does not match, the target does not acknowledge it, keeps SDA released and ignores the rest of the bus traffic until the next START. No register changes.
- R3: In a write, the sub-address byte and the data byte are each acknowledged, and the data byte is stored in the channel register that the sub-address selects.
- R4: A sub-address is valid only when bits 7 to 2 are zero and bits 1 to 0 are 0, 1 or 2. An invalid sub-address is not acknowledged, and both the read pointer and all registers keep their values.
- R5: A valid sub-address, acknowledged and followed by STOP, sets the read pointer. A later read transaction returns the selected register MSB first, in the eight clocks after the address acknowledge.
- R6: One transaction updates at most one register. A second data byte in the same write is not acknowledged and is not stored. The pointer never increments, so repeated reads return the same register.
- R7: A STOP in the middle of a byte abandons the transfer and leaves the registers unchanged. A START in the middle of a byte restarts reception at a fresh address byte.
- R8: After reset, all channel registers and the read pointer are zero and SDA is released. SDA is never pulled low while the target is idle.
- R9: The target changes its SDA drive only after a falling SCL edge and holds it steady while SCL stays high.
- R10: Output `chanCfg` holds channel n in bits 8n+7 down to 8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| strap | input | 2 | Low two bits of the target address |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND of all drivers) |
| sdaLow | output | 1 | 1 pulls SDA low, 0 releases it |
| chanCfg | output | 24 | Channel registers, channel n in byte lane n |

## Verification
The assertions assume a bus that follows I2C rules. SDA moves only while SCL is low, except to form START and STOP, and each SCL phase lasts several system clocks, so every edge passes through the synchronizer as a separate event. They also assume the master never forms START or STOP while the target is pulling SDA low. The bench's bit-banged master changes SDA only in the middle of the SCL low phase and holds each quarter bit for ten clocks. It issues STOP or a repeated START only at points where the target has released the line, including the two aborts in the middle of a byte.

// File: rtl/chanRegPkg.sv
package chanRegPkg;

  localparam logic [4:0] ADDR_PREFIX = 5'b01011;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACKWAIT,
    ST_ACK,
    ST_TX,
    ST_TXEND,
    ST_MACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic writeReg;
    logic ackOn;
    logic loadTx;
    logic shiftTx;
    logic releaseSda;
  } dpStrobe_t;

endpackage

// File: rtl/chanRegCtrl.sv
module chanRegCtrl
  import chanRegPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strap,
  input  logic [7:0] rxNext,
  output logic       sdaBit,
  output logic       sclLevel,
  output logic       busEvent,
  output logic       idleNow,
  output dpStrobe_t  strobe
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [PTR_W:0] CH_LIM = NUM_CH[PTR_W:0];

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state, nextState, afterAck, nextAfter;
  logic [2:0] bitCnt, nextCnt;
  logic byteDone;
  logic [6:0] myAddr;
  logic subOk;

  // two-flop sampling of the bus, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

  assign sdaBit   = sdaS;
  assign sclLevel = sclS;
  assign busEvent = startEv | stopEv;
  assign idleNow  = (state == ST_IDLE);

  assign myAddr = {ADDR_PREFIX, strap};
  assign subOk  = (rxNext[7:PTR_W] == '0) && ({1'b0, rxNext[PTR_W-1:0]} < CH_LIM);

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = bitCnt;
    nextAfter = afterAck;
    byteDone  = 1'b0;
    if (startEv) begin
      strobe.releaseSda = 1'b1;
      nextState = ST_ADDR;
      nextCnt   = '0;
    end else if (stopEv) begin
      strobe.releaseSda = 1'b1;
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            nextCnt = bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              byteDone = 1'b1;
              nextState = ST_IGNORE;
              if (state == ST_ADDR) begin
                if (rxNext[7:1] == myAddr) begin
                  nextState = ST_ACKWAIT;
                  nextAfter = rxNext[0] ? ST_TX : ST_SUB;
                end
              end else if (state == ST_SUB) begin
                if (subOk) begin
                  strobe.setPtr = 1'b1;
                  nextState = ST_ACKWAIT;
                  nextAfter = ST_WDATA;
                end
              end else begin
                strobe.writeReg = 1'b1;
                nextState = ST_ACKWAIT;
                nextAfter = ST_IGNORE;
              end
            end
          end
        end
        ST_ACKWAIT: if (sclFall) begin
          strobe.ackOn = 1'b1;
          nextState = ST_ACK;
        end
        ST_ACK: if (sclFall) begin
          nextCnt = '0;
          nextState = afterAck;
          if (afterAck == ST_TX) strobe.loadTx = 1'b1;
          else strobe.releaseSda = 1'b1;
        end
        ST_TX: begin
          if (sclRise) begin
            nextCnt = bitCnt + 3'd1;
            if (bitCnt == 3'd7) nextState = ST_TXEND;
          end else if (sclFall) begin
            strobe.shiftTx = 1'b1;
          end
        end
        ST_TXEND: if (sclFall) begin
          strobe.releaseSda = 1'b1;
          nextState = ST_MACK;
        end
        ST_MACK: if (sclRise) nextState = ST_IGNORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
    end else begin
      state    <= nextState;
      afterAck <= nextAfter;
      bitCnt   <= nextCnt;
    end
  end

  // at most one SDA drive action per cycle
  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ackOn, strobe.loadTx, strobe.shiftTx, strobe.releaseSda}));

  // a foreign address sends the target to ignore until the next START
  assert_nack_foreign_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && rxNext[7:1] != myAddr) |=> state == ST_IGNORE);

  // a rejected sub-address never reaches the acknowledge phase
  assert_bad_sub_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUB && byteDone && !subOk) |=> state != ST_ACKWAIT);

  // a STOP always returns to idle
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> state == ST_IDLE);

endmodule

// File: rtl/chanRegData.sv
module chanRegData
  import chanRegPkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  sdaBit,
  output logic [7:0]            rxNext,
  output logic                  sdaLow,
  output logic [NUM_CH*8-1:0]   chanCfg
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [PTR_W-1:0] ptr;
  logic [7:0] regs [NUM_CH];

  assign rxNext = {rxShift[6:0], sdaBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
      sdaLow  <= 1'b0;
    end else begin
      if (strobe.shiftIn) rxShift <= rxNext;
      if (strobe.setPtr)  ptr <= rxNext[PTR_W-1:0];
      if (strobe.releaseSda) begin
        sdaLow <= 1'b0;
      end else if (strobe.ackOn) begin
        sdaLow <= 1'b1;
      end else if (strobe.loadTx) begin
        txShift <= regs[ptr];
        sdaLow  <= ~regs[ptr][7];
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
        sdaLow  <= ~txShift[6];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[ch] <= '0;
      else if (strobe.writeReg && ptr == PTR_W'(ch)) regs[ch] <= rxNext;
    end
    assign chanCfg[ch*8 +: 8] = regs[ch];
  end

  // writes only ever address an existing channel
  assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeReg |-> ptr < PTR_W'(NUM_CH));

  // pointer moves only on an accepted sub-address
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setPtr |=> $stable(ptr));

endmodule

// File: rtl/chanRegI2c.sv
module chanRegI2c
  import chanRegPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          strap,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaLow,
  output logic [NUM_CH*8-1:0] chanCfg
);

  dpStrobe_t strobe;
  logic [7:0] rxNext;
  logic sdaBit, sclLevel, busEvent, idleNow;

  chanRegCtrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rxNext(rxNext), .sdaBit(sdaBit), .sclLevel(sclLevel),
    .busEvent(busEvent), .idleNow(idleNow), .strobe(strobe)
  );

  chanRegData #(.NUM_CH(NUM_CH)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .rxNext(rxNext), .sdaLow(sdaLow), .chanCfg(chanCfg)
  );

  // drive is frozen while SCL stays high, apart from a release at START/STOP
  assert_sda_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel) && !$past(busEvent)) |-> $stable(sdaLow));

  // nothing is driven while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    idleNow |-> !sdaLow);

endmodule

// File: tb/chanRegI2c_test.sv
module chanRegI2c_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] strap = 2'b00;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLow;
  logic [23:0] chanCfg;
  logic sdaLine;

  int errs = 0;
  int checks = 0;
  int viol = 0;
  int hiCnt = 0;
  logic prevLow = 1'b0;
  logic [6:0] dev = 7'h2C;
  logic [7:0] expReg [3];

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaLow;

  chanRegI2c uut (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaLow(sdaLow), .chanCfg(chanCfg)
  );

  // R9 monitor: drive must not move once SCL has been high for a while
  always @(negedge clk) begin
    if (sclM) hiCnt = hiCnt + 1; else hiCnt = 0;
    if (rstN && hiCnt > 4 && sdaLow != prevLow) viol = viol + 1;
    prevLow = sdaLow;
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; q(); sclM = 1'b1; q(); ack = ~sdaLine; q(); sclM = 1'b0; q();
  endtask

  task automatic readByte(output logic [7:0] d);
    d = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); sclM = 1'b1; q(); d = {d[6:0], sdaLine}; q(); sclM = 1'b0;
    end
    q();
    sendBit(1'b1);
  endtask

  task automatic doWrite(input logic [7:0] sub, input logic [7:0] val,
                         output logic a0, output logic a1, output logic a2);
    a1 = 1'b0; a2 = 1'b0;
    i2cStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(sub, a1);
    sendByte(val, a2);
    i2cStop();
  endtask

  task automatic doSetPtr(input logic [7:0] sub, output logic a0, output logic a1);
    i2cStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(sub, a1);
    i2cStop();
  endtask

  task automatic doRead(output logic a0, output logic [7:0] d);
    i2cStart();
    sendByte({dev, 1'b1}, a0);
    d = '0;
    if (a0) readByte(d);
    i2cStop();
  endtask

  task automatic checkLanes(input string tag);
    for (int c = 0; c < 3; c++)
      check(chanCfg[c*8 +: 8] == expReg[c], tag, chanCfg[c*8 +: 8], expReg[c]);
  endtask

  task automatic testReset();
    logic a0; logic [7:0] d;
    check(chanCfg == 24'h0, "R8 reset registers", chanCfg, 0);
    check(sdaLow == 1'b0, "R8 reset SDA released", sdaLow, 0);
    doRead(a0, d);
    check(a0, "R1 read address ack", a0, 1);
    check(d == 8'h00, "R8 R5 pointer resets to channel 0", d, 0);
  endtask

  task automatic testWriteAll();
    logic a0, a1, a2;
    logic [7:0] vals [3];
    vals[0] = 8'hF5; vals[1] = 8'h3C; vals[2] = 8'h81;
    for (int c = 0; c < 3; c++) begin
      doWrite(8'(c), vals[c], a0, a1, a2);
      check(a0, "R1 address ack on write", a0, 1);
      check(a1 && a2, "R3 sub and data ack", {a1, a2}, 3);
      expReg[c] = vals[c];
    end
    checkLanes("R3 R10 lanes after writes");
  endtask

  task automatic testReadBack();
    logic a0, a1; logic [7:0] d;
    for (int c = 2; c >= 0; c--) begin
      doSetPtr(8'(c), a0, a1);
      check(a1, "R5 pointer write ack", a1, 1);
      doRead(a0, d);
      check(d == expReg[c], "R5 read returns selected channel", d, expReg[c]);
    end
  endtask

  task automatic testWrongAddr();
    logic a0, a1, a2;
    logic [6:0] keep;
    keep = dev;
    dev = 7'h2D;
    doWrite(8'h00, 8'h5A, a0, a1, a2);
    check(!a0, "R2 foreign address not acked", a0, 0);
    check(!a1 && !a2, "R2 later bytes ignored", {a1, a2}, 0);
    checkLanes("R2 registers unchanged");
    dev = keep;
    doWrite(8'h01, 8'h66, a0, a1, a2);
    check(a0 && a1 && a2, "R2 next START recovers", {a0, a1, a2}, 7);
    expReg[1] = 8'h66;
    checkLanes("R2 recovery write");
  endtask

  task automatic testBadSub();
    logic a0, a1, a2; logic [7:0] d;
    doSetPtr(8'h01, a0, a1);
    doSetPtr(8'h03, a0, a1);
    check(!a1, "R4 channel 3 not acked", a1, 0);
    doSetPtr(8'h04, a0, a1);
    check(!a1, "R4 bit 2 set not acked", a1, 0);
    doWrite(8'h80, 8'hEE, a0, a1, a2);
    check(!a1 && !a2, "R4 bit 7 set not acked", {a1, a2}, 0);
    checkLanes("R4 registers unchanged");
    doRead(a0, d);
    check(d == expReg[1], "R4 pointer kept", d, expReg[1]);
  endtask

  task automatic testOneReg();
    logic a0, a1, a2, a3; logic [7:0] d;
    i2cStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(8'h02, a1);
    sendByte(8'h11, a2);
    sendByte(8'h22, a3);
    i2cStop();
    check(a2, "R6 first data acked", a2, 1);
    check(!a3, "R6 second data not acked", a3, 0);
    expReg[2] = 8'h11;
    checkLanes("R6 only one register written");
    doRead(a0, d);
    check(d == 8'h11, "R6 first read", d, 8'h11);
    doRead(a0, d);
    check(d == 8'h11, "R6 no auto increment", d, 8'h11);
  endtask

  task automatic testAbort();
    logic a0, a1, a2;
    i2cStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(8'h00, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    i2cStop();
    checkLanes("R7 STOP mid byte no write");
    i2cStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    doWrite(8'h00, 8'h99, a0, a1, a2);
    check(a0 && a1 && a2, "R7 restart mid byte acks", {a0, a1, a2}, 7);
    expReg[0] = 8'h99;
    checkLanes("R7 write after restart");
  endtask

  task automatic testStrap();
    logic a0, a1, a2;
    strap = 2'b11;
    q();
    dev = 7'h2C;
    doWrite(8'h01, 8'h5A, a0, a1, a2);
    check(!a0, "R1 old address rejected after strap change", a0, 0);
    dev = 7'h2F;
    doWrite(8'h01, 8'h5A, a0, a1, a2);
    check(a0 && a1 && a2, "R1 strap address acked", {a0, a1, a2}, 7);
    expReg[1] = 8'h5A;
    checkLanes("R1 R10 strap write");
  endtask

  initial begin
    for (int c = 0; c < 3; c++) expReg[c] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWriteAll();
    testReadBack();
    testWrongAddr();
    testBadSub();
    testOneReg();
    testAbort();
    testStrap();
    check(viol == 0, "R9 drive steady while SCL high", viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule